// File: doc/BRIEF.md
# Store-and-Forward DMA Transfer Engine

This block moves data for one DMA channel as a master on a pipelined system bus. The bus has an address phase and a data phase, a ready input that stretches the data phase, and an error response. Every single transfer first reads a burst of elements into an internal beat buffer. It then writes the same number of elements back out from that buffer. Moves between any two bus slaves therefore work: memory to memory, memory to a fixed peripheral data register, or a peripheral register to memory.

Software sets the source and destination addresses, an increment enable for each side, the element size, the burst length and the number of single transfers in a block. These settings are captured when the start pulse is accepted. In software mode the start pulse runs the whole block back to back. In request mode the start pulse only arms the channel. Each single transfer then waits for the peripheral's asynchronous request line, and is answered by an acknowledge pulse once its write burst has finished. The peripheral can cut a block short with an end-of-process input. An error response from the bus aborts the block and sets an error flag.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is low and after it is released, `htrans` is IDLE (2'b00) and `busy`, `dack`, `done` and `err` are all low.
- R2: A single transfer is one read burst of `burst_len` beats (`hwrite`=0; first beat NONSEQ 2'b10, the rest SEQ 2'b11), followed by one write burst of `burst_len` beats (`hwrite`=1). A NONSEQ address is never issued while a data phase is still open.
- R3: In the cycle after the final data phase of any burst completes, `htrans` is IDLE. In software mode the next burst's NONSEQ follows in the cycle after that.
- R4: A block consists of `xfer_count` single transfers. When it finishes, `done` is high for exactly one cycle and `busy` drops in the next cycle.
- R5: `elem_size` selects 8, 16 or 32 bits (codes 0, 1, 2), and `hsize` carries the same code. Byte lanes are big-endian: the byte at address offset k occupies `hrdata`/`hwdata` bits [31-8k -: 8]. Each element is taken from the lanes of its source address and written to the lanes of its destination address.
- R6: With its increment enable set, the source or destination address advances by the element size in bytes after each beat. With the enable clear, that address stays fixed. Addresses carry on across the transfers of a block.
- R7: In request mode no transfer starts until the synchronised `dreq` is seen high. `dack` is high for exactly one cycle after each transfer's write burst. A request that stays high past its `dack` does not start another transfer until `dreq` has been seen low.
- R8: If `eop` is high during, or before, the cycle in which the last write beat of a transfer completes, the block ends after that transfer. If `eop` is raised later, exactly one more transfer completes and then the block ends.
- R9: `hresp`=1 on a beat that has `hready`=1 aborts the block. The bus is IDLE in the next cycle, `busy` drops, `err` rises and no `done` is produced. No later beat is written. `err` stays high until the next accepted start.
- R10: A start pulse while `busy` is high is ignored. The running block keeps its captured settings.
- R11: While `hready` is low, the address, `htrans` and `hwrite` are held, and the data moved is the same as with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; captures the settings when idle |
| hw_mode | input | 1 | 1: each transfer waits for `dreq`; 0: block runs on the start alone |
| src_addr | input | AW | First source address |
| dst_addr | input | AW | First destination address |
| src_inc | input | 1 | Advance the source address per beat |
| dst_inc | input | 1 | Advance the destination address per beat |
| elem_size | input | SZW | Element size code (0: 8, 1: 16, 2: 32 bits) |
| burst_len | input | LEN_W | Beats per burst, 1 to MAX_BURST |
| xfer_count | input | CNT_W | Single transfers per block, at least 1 |
| dreq | input | 1 | Asynchronous peripheral request |
| eop | input | 1 | End-of-process from the peripheral |
| dack | output | 1 | One-cycle acknowledge after a requested transfer |
| busy | output | 1 | A block is active |
| done | output | 1 | One-cycle pulse at the end of the block |
| err | output | 1 | Sticky bus-error flag |
| htrans | output | 2 | Transfer type: IDLE, NONSEQ, SEQ |
| haddr | output | AW | Address-phase address |
| hwrite | output | 1 | 1 for a write burst |
| hsize | output | 3 | Element size code |
| hwdata | output | DW | Write data, valid in the data phase |
| hrdata | input | DW | Read data, sampled in the data phase |
| hready | input | 1 | Data phase completes when high |
| hresp | input | 1 | Error response for the completing beat |

## Verification
Lane steering is exercised with byte elements whose source and destination offsets differ. A design that swapped byte order or ignored the offset would write bytes into the wrong locations. Fixed-address sources and destinations are included, so a design that incremented anyway would scatter data. The end-of-process input is driven in the exact final write data-phase cycle and again one cycle later. A cutoff off by one cycle shows up as a transfer count of two instead of one, or one instead of two. Further tests cover an error on a mid-burst read beat, which must leave the destination untouched; a request held long past its acknowledge, which must not start an extra transfer; and a burst started back to back without the idle cycle, which the bench counts as a gap violation.

// File: rtl/dma_xfer_pkg.sv
// Shared definitions for the DMA transfer engine.
// Assumes a bus whose transfer type encoding matches the common pipelined
// system bus: IDLE 2'b00, NONSEQ 2'b10, SEQ 2'b11.
package dma_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // no block active
        ST_WAIT,    // armed, waiting for a peripheral request
        ST_RD,      // read burst into the beat buffer
        ST_GAPR,    // idle bus cycle after the read burst
        ST_WR,      // write burst out of the beat buffer
        ST_GAPW     // idle bus cycle after the write burst
    } mover_st_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

endpackage

// File: rtl/dma_req_sync.sv
// Multi-flop synchroniser for the asynchronous request line.
// Assumes STAGES >= 2; the output lags the input by STAGES clocks.
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/dma_lane_steer.sv
// Big-endian byte-lane steering between a bus word and a right-justified
// element. Byte offset k of a word lives in bits [DW-1-8k -: 8].
// Assumes the element is naturally aligned to its size.
module dma_lane_steer #(
    parameter int DW  = 32,
    parameter int SZW = 2,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  logic [DW-1:0]  bus_in,
    input  logic [DW-1:0]  elem_in,
    input  logic [OW-1:0]  off,
    input  logic [SZW-1:0] esize,
    output logic [DW-1:0]  elem_out,
    output logic [DW-1:0]  bus_out
);

    // Compute the shift and mask for the element's lanes, then extract and insert.
    always_comb begin
        int nbytes;
        int sh;
        logic [DW-1:0] mask;
        nbytes = 1 << esize;
        if (nbytes > NB) nbytes = NB;
        sh = (NB - int'(off) - nbytes) * 8;
        if (sh < 0) sh = 0;
        mask = {DW{1'b1}} >> (DW - nbytes * 8);
        elem_out = (bus_in >> sh) & mask;
        bus_out  = (elem_in & mask) << sh;
    end

endmodule

// File: rtl/dma_beat_buf.sv
// Beat buffer holding one full read burst. It is indexed by the beat
// number, because a burst is always written in full before it is read back.
// Storage has no reset: every entry read is written first in the same transfer.
module dma_beat_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] store [DEPTH];

    // Capture one element per completed read beat.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    assign rd_data = store[rd_idx];

endmodule

// File: rtl/dma_xfer_engine.sv
// Store-and-forward DMA transfer engine for one channel.
// Each single transfer reads burst_len elements into a beat buffer, inserts
// one idle bus cycle, writes them back, then inserts another idle cycle.
// Assumes a grant is always held, burst_len in 1..MAX_BURST, xfer_count >= 1,
// aligned addresses, and DW >= 16.
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int MAX_BURST   = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int NB    = DW / 8,
    localparam int OW    = $clog2(NB),
    localparam int IW    = $clog2(MAX_BURST),
    localparam int LEN_W = $clog2(MAX_BURST) + 1,
    localparam int SZW   = (OW < 2) ? 1 : $clog2(OW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hw_mode,
    input  logic [AW-1:0]    src_addr,
    input  logic [AW-1:0]    dst_addr,
    input  logic             src_inc,
    input  logic             dst_inc,
    input  logic [SZW-1:0]   elem_size,
    input  logic [LEN_W-1:0] burst_len,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             dreq,
    input  logic             eop,
    output logic             dack,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [1:0]       htrans,
    output logic [AW-1:0]    haddr,
    output logic             hwrite,
    output logic [2:0]       hsize,
    output logic [DW-1:0]    hwdata,
    input  logic [DW-1:0]    hrdata,
    input  logic             hready,
    input  logic             hresp
);

    mover_st_e        st;
    logic [AW-1:0]    src_ptr, dst_ptr, step;
    logic [LEN_W-1:0] len_q, addr_cnt, data_cnt;
    logic [CNT_W-1:0] cnt_q, xfer_cnt;
    logic [SZW-1:0]   esz_q;
    logic             sinc_q, dinc_q, hwm_q;
    logic             dp_valid, eop_pend, fin_q, err_q, armed, req_s;
    logic [OW-1:0]    dp_off;
    logic             in_burst, burst_act, accept, beat_done, beat_err, last_beat;
    logic [DW-1:0]    rd_elem, buf_rd;

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(dreq), .sync_out(req_s)
    );

    dma_lane_steer #(.DW(DW), .SZW(SZW)) u_lanes (
        .bus_in(hrdata), .elem_in(buf_rd), .off(dp_off), .esize(esz_q),
        .elem_out(rd_elem), .bus_out(hwdata)
    );

    dma_beat_buf #(.DW(DW), .DEPTH(MAX_BURST)) u_buf (
        .clk(clk), .wr_en(st == ST_RD && beat_done && !hresp),
        .wr_idx(data_cnt[IW-1:0]), .wr_data(rd_elem),
        .rd_idx(data_cnt[IW-1:0]), .rd_data(buf_rd)
    );

    // Address-phase drive and beat handshake decode.
    always_comb begin
        in_burst  = (st == ST_RD) || (st == ST_WR);
        burst_act = in_burst && (addr_cnt < len_q);
        htrans    = burst_act ? ((addr_cnt == '0) ? TR_NONSEQ : TR_SEQ) : TR_IDLE;
        haddr     = (st == ST_WR) ? dst_ptr : src_ptr;
        hwrite    = (st == ST_WR);
        hsize     = 3'(esz_q);
        step      = AW'(1) << esz_q;
        accept    = burst_act && hready;
        beat_done = dp_valid && hready;
        beat_err  = beat_done && hresp;
        last_beat = in_burst && beat_done && !hresp && (data_cnt == len_q - 1'b1);
    end

    assign busy = (st != ST_IDLE);
    assign dack = (st == ST_GAPW) && hwm_q;
    assign done = (st == ST_GAPW) && fin_q;
    assign err  = err_q;

    // Track the open data phase and the byte offset of its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_valid <= 1'b0;
            dp_off   <= '0;
        end else begin
            if (beat_err)    dp_valid <= 1'b0;
            else if (accept) dp_valid <= 1'b1;
            else if (hready) dp_valid <= 1'b0;
            if (accept) dp_off <= haddr[OW-1:0];
        end
    end

    // Re-arm the request only after the synchronised line has been seen low.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed <= 1'b1;
        else if (!req_s)         armed <= 1'b1;
        else if (st == ST_WAIT)  armed <= 1'b0;
    end

    // Block sequencing: capture, bursts, gaps, end-of-process and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            src_ptr <= '0;  dst_ptr <= '0;
            len_q <= '0;    cnt_q <= '0;   esz_q <= '0;
            sinc_q <= 1'b0; dinc_q <= 1'b0; hwm_q <= 1'b0;
            addr_cnt <= '0; data_cnt <= '0; xfer_cnt <= '0;
            eop_pend <= 1'b0; fin_q <= 1'b0; err_q <= 1'b0;
        end else begin
            if (eop && st != ST_IDLE) eop_pend <= 1'b1;
            case (st)
                ST_IDLE: if (start) begin
                    src_ptr  <= src_addr;   dst_ptr <= dst_addr;
                    len_q    <= burst_len;  cnt_q   <= xfer_count;
                    esz_q    <= elem_size;  hwm_q   <= hw_mode;
                    sinc_q   <= src_inc;    dinc_q  <= dst_inc;
                    addr_cnt <= '0; data_cnt <= '0; xfer_cnt <= '0;
                    eop_pend <= 1'b0; fin_q <= 1'b0; err_q <= 1'b0;
                    st <= hw_mode ? ST_WAIT : ST_RD;
                end
                ST_WAIT: if (req_s && armed) st <= ST_RD;
                ST_RD, ST_WR: begin
                    if (accept) begin
                        addr_cnt <= addr_cnt + 1'b1;
                        if (st == ST_RD && sinc_q) src_ptr <= src_ptr + step;
                        if (st == ST_WR && dinc_q) dst_ptr <= dst_ptr + step;
                    end
                    if (beat_done && !hresp) data_cnt <= data_cnt + 1'b1;
                    if (last_beat) begin
                        addr_cnt <= '0;
                        data_cnt <= '0;
                        if (st == ST_RD) begin
                            st <= ST_GAPR;
                        end else begin
                            st       <= ST_GAPW;
                            fin_q    <= (xfer_cnt == cnt_q - 1'b1) || eop || eop_pend;
                            xfer_cnt <= xfer_cnt + 1'b1;
                        end
                    end
                    if (beat_err) begin
                        st <= ST_IDLE;
                        err_q <= 1'b1;
                        addr_cnt <= '0;
                        data_cnt <= '0;
                    end
                end
                ST_GAPR: st <= ST_WR;
                ST_GAPW: begin
                    if (fin_q)      st <= ST_IDLE;
                    else if (hwm_q) st <= ST_WAIT;
                    else            st <= ST_RD;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // A new burst never opens on top of an unfinished data phase (R2).
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_NONSEQ) |-> !dp_valid);

    // A final completing beat with no next address leaves the bus idle next cycle (R3).
    assert_idle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && hready && !hresp && !htrans[1]) |=> (htrans == TR_IDLE));

    // Block completion is a single-cycle pulse followed by idle (R4).
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // Acknowledge lasts exactly one cycle (R7).
    assert_dack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> !dack);

    // Error response aborts the block at once (R9).
    assert_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && hready && hresp) |=> (!busy && err && htrans == TR_IDLE));

    // Address and control hold through wait states (R11).
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans[1] && !hready) |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite)));

endmodule

// File: tb/dma_xfer_engine_tb.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb;

    typedef struct packed {
        logic [7:0] src;
        logic [7:0] dst;
        logic [1:0] esz;
        logic [4:0] len;
        logic [3:0] cnt;
        logic       sinc;
        logic       dinc;
        logic       ws;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h80, 2'd2, 5'd4,  4'd2, 1'b1, 1'b1, 1'b0},
        '{8'h10, 8'hA0, 2'd1, 5'd3,  4'd2, 1'b1, 1'b1, 1'b1},
        '{8'h21, 8'hC3, 2'd0, 5'd5,  4'd1, 1'b1, 1'b1, 1'b0},
        '{8'h40, 8'hF0, 2'd2, 5'd4,  4'd1, 1'b1, 1'b0, 1'b0},
        '{8'h05, 8'h90, 2'd0, 5'd4,  4'd2, 1'b0, 1'b1, 1'b1},
        '{8'h00, 8'h80, 2'd2, 5'd16, 4'd1, 1'b1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, hw_mode = 1'b0, src_inc = 1'b1, dst_inc = 1'b1;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic [1:0]  elem_size = '0;
    logic [4:0]  burst_len = 5'd1;
    logic [15:0] xfer_count = 16'd1;
    logic        dreq = 1'b0, eop = 1'b0;
    logic        dack, busy, done, err, hwrite, hready, hresp;
    logic [1:0]  htrans;
    logic [31:0] haddr, hwdata, hrdata;
    logic [2:0]  hsize;

    dma_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hw_mode(hw_mode),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_inc(src_inc), .dst_inc(dst_inc),
        .elem_size(elem_size), .burst_len(burst_len), .xfer_count(xfer_count),
        .dreq(dreq), .eop(eop), .dack(dack), .busy(busy), .done(done), .err(err),
        .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hsize(hsize),
        .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
    );

    always #2.5 clk = ~clk;

    // Slave memory model and bus monitor
    logic [7:0]  mem [256];
    logic [7:0]  exp_mem [256];
    logic        dp_v = 1'b0, dp_w = 1'b0, ws_tog = 1'b0, ws_en = 1'b0;
    logic        err_en = 1'b0, prev_comp = 1'b0, dack_prev = 1'b0;
    logic [31:0] dp_a = '0;
    logic [2:0]  dp_sz = '0;
    logic [5:0]  err_word = '0;
    int rd_beats = 0, wr_beats = 0, gap_viol = 0, dack_cnt = 0, dack_dbl = 0, done_cnt = 0;
    int n_checks = 0, n_fail = 0;

    assign hready = !ws_en || ws_tog;
    assign hresp  = dp_v && err_en && (dp_a[7:2] == err_word);
    assign hrdata = {mem[{dp_a[7:2], 2'b00}], mem[{dp_a[7:2], 2'b01}],
                     mem[{dp_a[7:2], 2'b10}], mem[{dp_a[7:2], 2'b11}]};

    always @(posedge clk) begin
        if (!rst_n) begin
            dp_v <= 1'b0;
            ws_tog <= 1'b0;
            prev_comp <= 1'b0;
            dack_prev <= 1'b0;
        end else begin
            ws_tog <= ~ws_tog;
            if (dp_v && hready && !hresp) begin
                if (dp_w) begin
                    for (int k = 0; k < 4; k++)
                        if (k >= int'(dp_a[1:0]) && k < int'(dp_a[1:0]) + (1 << dp_sz))
                            mem[{dp_a[7:2], 2'(k)}] <= hwdata[31-8*k -: 8];
                    wr_beats <= wr_beats + 1;
                end else begin
                    rd_beats <= rd_beats + 1;
                end
            end
            if (hready) begin
                dp_v  <= htrans[1];
                dp_a  <= haddr;
                dp_w  <= hwrite;
                dp_sz <= hsize;
            end
            prev_comp <= dp_v && hready;
            if (htrans == 2'b10 && (dp_v || prev_comp)) gap_viol <= gap_viol + 1;
            if (dack) dack_cnt <= dack_cnt + 1;
            if (dack && dack_prev) dack_dbl <= dack_dbl + 1;
            dack_prev <= dack;
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 37 + 11);
            exp_mem[i] = 8'(i * 37 + 11);
        end
    endtask

    // Reference move computed from the requirements, byte by byte
    task automatic ref_move(input int s, input int d, input int esz, input int len,
                            input int cnt, input bit si, input bit di);
        int n;
        n = 1 << esz;
        for (int t = 0; t < cnt; t++)
            for (int b = 0; b < len; b++) begin
                for (int k = 0; k < n; k++) exp_mem[(d + k) & 255] = exp_mem[(s + k) & 255];
                if (si) s += n;
                if (di) d += n;
            end
    endtask

    function automatic int mem_diff();
        int c;
        c = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) c++;
        return c;
    endfunction

    task automatic setup(input int s, input int d, input int esz, input int len,
                         input int cnt, input bit si, input bit di, input bit hw);
        @(negedge clk);
        src_addr = 32'(s); dst_addr = 32'(d); elem_size = 2'(esz);
        burst_len = 5'(len); xfer_count = 16'(cnt);
        src_inc = si; dst_inc = di; hw_mode = hw;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (busy) chk(1'b0, "R4", "block never finished", 1, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R4", "watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int rd0, wr0, dn0, gv0, dk0, dd0, t;
        init_mem();

        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        chk(htrans == 2'b00 && !busy && !dack && !done && !err, "R1", "outputs in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(htrans == 2'b00, "R1", "htrans after reset", int'(htrans), 0);
        chk(!busy && !dack && !done && !err, "R1", "status after reset",
            int'({busy, dack, done, err}), 0);

        // Table walk: R2 R3 R4 R5 R6 R11
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            init_mem();
            ws_en = v.ws;
            ref_move(int'(v.src), int'(v.dst), int'(v.esz), int'(v.len), int'(v.cnt), v.sinc, v.dinc);
            rd0 = rd_beats; wr0 = wr_beats; dn0 = done_cnt; gv0 = gap_viol;
            setup(int'(v.src), int'(v.dst), int'(v.esz), int'(v.len), int'(v.cnt), v.sinc, v.dinc, 1'b0);
            pulse_start();
            wait_idle();
            repeat (2) @(negedge clk);
            chk(mem_diff() == 0, "R5 R6 R11", $sformatf("vector %0d memory mismatches", i), mem_diff(), 0);
            chk(rd_beats - rd0 == int'(v.len) * int'(v.cnt) && wr_beats - wr0 == int'(v.len) * int'(v.cnt),
                "R2", $sformatf("vector %0d write beats", i), wr_beats - wr0, int'(v.len) * int'(v.cnt));
            chk(done_cnt - dn0 == 1, "R4", $sformatf("vector %0d done pulses", i), done_cnt - dn0, 1);
            chk(gap_viol == gv0, "R3", $sformatf("vector %0d gap violations", i), gap_viol - gv0, 0);
        end
        ws_en = 1'b0;

        // R10: a second start while busy is ignored
        init_mem();
        ref_move(8'h00, 8'h80, 2, 8, 2, 1'b1, 1'b1);
        dn0 = done_cnt;
        setup(8'h00, 8'h80, 2, 8, 2, 1'b1, 1'b1, 1'b0);
        pulse_start();
        repeat (6) @(negedge clk);
        src_addr = 32'h60; dst_addr = 32'hE0;
        pulse_start();
        wait_idle();
        repeat (2) @(negedge clk);
        chk(mem_diff() == 0, "R10", "memory after ignored start", mem_diff(), 0);
        chk(done_cnt - dn0 == 1, "R10", "done pulses", done_cnt - dn0, 1);

        // R7: request mode
        init_mem();
        ref_move(8'h00, 8'h80, 2, 2, 3, 1'b1, 1'b1);
        rd0 = rd_beats; dn0 = done_cnt; dk0 = dack_cnt; dd0 = dack_dbl;
        setup(8'h00, 8'h80, 2, 2, 3, 1'b1, 1'b1, 1'b1);
        pulse_start();
        repeat (20) @(negedge clk);
        chk(busy && rd_beats == rd0, "R7", "reads before request", rd_beats - rd0, 0);
        for (int r = 0; r < 3; r++) begin
            dreq = 1'b1;
            t = 0;
            while (!dack && t < 2000) begin
                @(negedge clk);
                t++;
            end
            if (r == 1) repeat (10) @(negedge clk);
            dreq = 1'b0;
            if (r == 1) begin
                repeat (6) @(negedge clk);
                chk(rd_beats - rd0 == 4, "R7", "reads after held request", rd_beats - rd0, 4);
            end
            @(negedge clk);
        end
        wait_idle();
        repeat (2) @(negedge clk);
        chk(dack_cnt - dk0 == 3, "R7", "acknowledge pulses", dack_cnt - dk0, 3);
        chk(dack_dbl == dd0, "R7", "multi-cycle acknowledge", dack_dbl - dd0, 0);
        chk(mem_diff() == 0 && done_cnt - dn0 == 1, "R7", "request-mode memory", mem_diff(), 0);

        // R8: eop in the final write data-phase cycle ends after one transfer
        init_mem();
        ref_move(8'h00, 8'h80, 2, 4, 1, 1'b1, 1'b1);
        wr0 = wr_beats;
        setup(8'h00, 8'h80, 2, 4, 4, 1'b1, 1'b1, 1'b0);
        pulse_start();
        t = 0;
        while (wr_beats - wr0 != 3 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        eop = 1'b1;
        @(negedge clk) eop = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
        chk(wr_beats - wr0 == 4, "R8", "write beats, eop on last beat", wr_beats - wr0, 4);
        chk(mem_diff() == 0, "R8", "memory, eop on last beat", mem_diff(), 0);

        // R8: eop one cycle later gives one more transfer
        init_mem();
        ref_move(8'h00, 8'h80, 2, 4, 2, 1'b1, 1'b1);
        wr0 = wr_beats;
        setup(8'h00, 8'h80, 2, 4, 4, 1'b1, 1'b1, 1'b0);
        pulse_start();
        t = 0;
        while (wr_beats - wr0 != 4 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        eop = 1'b1;
        @(negedge clk) eop = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
        chk(wr_beats - wr0 == 8, "R8", "write beats, late eop", wr_beats - wr0, 8);
        chk(mem_diff() == 0, "R8", "memory, late eop", mem_diff(), 0);

        // R9: error on the third read beat aborts with nothing written
        init_mem();
        err_word = 6'h12;
        err_en = 1'b1;
        wr0 = wr_beats; dn0 = done_cnt;
        setup(8'h40, 8'hB0, 2, 4, 2, 1'b1, 1'b1, 1'b0);
        pulse_start();
        wait_idle();
        repeat (2) @(negedge clk);
        chk(err && !busy && htrans == 2'b00, "R9", "error flag after abort", int'(err), 1);
        chk(wr_beats == wr0 && mem_diff() == 0, "R9", "writes after abort", wr_beats - wr0, 0);
        chk(done_cnt == dn0, "R9", "done pulses on abort", done_cnt - dn0, 0);
        err_en = 1'b0;
        ref_move(8'h00, 8'h80, 2, 2, 1, 1'b1, 1'b1);
        setup(8'h00, 8'h80, 2, 2, 1, 1'b1, 1'b1, 1'b0);
        pulse_start();
        chk(!err, "R9", "error flag after new start", int'(err), 0);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(mem_diff() == 0, "R9", "memory after recovery", mem_diff(), 0);

        summary();
        $finish;
    end

endmodule